// File: doc/BRIEF.md
# Serial DAC Frame Sequencer

This block sits on the controller side of a three- or four-wire link to a 12-bit serial DAC. It accepts one command at a time through a ready/valid handshake and turns it into one or two 16-bit frames on a chip-select line, a frame-sync line, a divided serial clock and a data line. A frame is opened by pulling chip select low, then frame sync low. Sixteen bits are then shifted out, most significant first, and the receiver samples each bit on a falling clock edge. One more rising edge follows, and then frame sync and chip select are released together.

A full command carries a 2-bit register select, a speed bit, a power-down bit and a 12-bit payload, and it is sent as a single frame. A value-only command carries a new output code together with the speed and reference setting it needs. The block keeps the speed and reference code of the last control frame it sent. When the request matches them, only the data frame goes out. Otherwise a control frame is sent first and the data frame follows. An optional byte mode splits the 16 bits into two 8-bit bursts with an idle clock gap between them, and the frame stays open across the gap.

Top module: `dac_frame_seq`

## Requirements
- R1: Each frame begins with chip select low and frame sync high for one half period. Frame sync then goes low for one half period before the first SCLK rising edge. Frame sync is never low while chip select is high.
- R2: A frame holds exactly 16 SCLK falling edges, and the first bit sent is the most significant. SCLK idles low. DIN holds its value through each high phase and across each falling edge.
- R3: Every SCLK high phase and every ordinary low phase lasts L clock cycles. The frame-sync lead phases also last L cycles. L equals `cfg_half`, except that a value of 0 gives L = 1.
- R4: After the 16th falling edge SCLK rises once more and stays high for L cycles. In the next cycle SCLK falls, and frame sync and chip select rise together.
- R5: A full command is sent as the word {sel[1], fast, pdown, sel[0], payload[11:0]}, from bit 15 down to bit 0.
- R6: A value-only command whose fast bit and 2-bit reference code equal the remembered ones produces only the data frame {0, fast, 0, 0, value[11:0]}.
- R7: A value-only command that does not match, or that arrives when nothing is remembered, produces the control frame {1, fast, 0, 1, 10 zero bits, ref[1:0]} first. Chip select is then released, and the data frame of R6 follows.
- R8: The remembered setting is cleared by reset. A full command with sel = 11 loads it with {fast, payload[1:0]}, and a control frame sent under R7 also loads it.
- R9: With `cfg_byte_mode` high when a frame starts, the low phase that follows the 8th falling edge lasts 3·L cycles. Chip select and frame sync stay low through that gap.
- R10: `busy` is high from the cycle after a command is accepted until chip select has returned high after the last frame. `cmd_ready` is low while busy, and a command presented while busy is not taken.
- R11: During and right after reset, chip select and frame sync are high, SCLK is low, `busy` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | HALF_W | Clock cycles per SCLK half period (0 treated as 1) |
| cfg_byte_mode | input | 1 | Send the frame as two 8-bit bursts |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_value_only | input | 1 | 1: value-only request, 0: full command |
| cmd_sel | input | 2 | Register select {R1,R0} for full commands |
| cmd_fast | input | 1 | Speed bit |
| cmd_pdown | input | 1 | Power-down bit (full commands) |
| cmd_ref | input | 2 | Reference code for value-only requests |
| cmd_payload | input | 12 | Payload or DAC code |
| busy | output | 1 | Command in progress |
| ser_cs_n | output | 1 | Chip select, active low |
| ser_fs | output | 1 | Frame sync, falls to open a frame |
| ser_sclk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data |

## Verification
The in-design assertions check the line protocol on every cycle. They cover the frame-sync-inside-chip-select rule and the frame-sync-before-clock order, DIN staying stable across falling edges, the minimum high and low phase lengths, sixteen falling edges per frame, and the closing rising edge. They also cover the busy/handshake relation. The word contents can only be shown by the scoreboard scenarios: the bit layout of full commands, whether a control frame is skipped or inserted for value-only requests, the remembered setting across reset, the exact byte-mode gap length and back-pressure.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int DATA_W     = 12;
  localparam int FRAME_W    = DATA_W + 4;
  localparam int BYTE_W     = 8;
  localparam int GAP_HALVES = 2;
  localparam int REF_W      = 2;

  localparam logic [1:0] SEL_CTRL = 2'b11;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CS, PH_FS, PH_HI, PH_LO, PH_GAP, PH_TAIL, PH_REL
  } phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOAD1, SQ_WAIT1, SQ_LOAD2, SQ_WAIT2
  } seq_t;
endpackage

// File: rtl/dfs_half_timer.sv
module dfs_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic [HALF_W-1:0] lim,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  assign lim  = (half_len == '0) ? HALF_W'(1) : half_len;
  assign tick = run && (cnt_q == lim - HALF_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dfs_word_build.sv
module dfs_word_build
  import dfs_pkg::*;
(
  input  logic              value_only,
  input  logic [1:0]        sel,
  input  logic              fast,
  input  logic              pdown,
  input  logic [REF_W-1:0]  ref_code,
  input  logic [DATA_W-1:0] payload,
  input  logic              mem_vld,
  input  logic              mem_fast,
  input  logic [REF_W-1:0]  mem_ref,
  output frame_t            first,
  output frame_t            second,
  output logic              two,
  output logic              upd,
  output logic              new_fast,
  output logic [REF_W-1:0]  new_ref
);
  frame_t ctrl_w, data_w, full_w;
  logic   match;

  assign full_w = {sel[1], fast, pdown, sel[0], payload};
  assign ctrl_w = {1'b1, fast, 1'b0, 1'b1, {(DATA_W-REF_W){1'b0}}, ref_code};
  assign data_w = {1'b0, fast, 1'b0, 1'b0, payload};
  assign match  = mem_vld && (mem_fast == fast) && (mem_ref == ref_code);

  always_comb begin
    new_fast = fast;
    if (!value_only) begin
      first   = full_w;
      second  = '0;
      two     = 1'b0;
      upd     = (sel == SEL_CTRL);
      new_ref = payload[REF_W-1:0];
    end else if (match) begin
      first   = data_w;
      second  = '0;
      two     = 1'b0;
      upd     = 1'b0;
      new_ref = ref_code;
    end else begin
      first   = ctrl_w;
      second  = data_w;
      two     = 1'b1;
      upd     = 1'b1;
      new_ref = ref_code;
    end
  end
endmodule

// File: rtl/dfs_frame_engine.sv
module dfs_frame_engine
  import dfs_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_t            word,
  input  logic              byte_mode,
  input  logic              tick,
  input  logic [HALF_W-1:0] lim,
  output logic              run,
  output logic              done,
  output logic              cs_n,
  output logic              fs,
  output logic              sclk,
  output logic              dout
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam int GAP_W = $clog2(GAP_HALVES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] BYTE_IDX = IDX_W'(BYTE_W - 1);
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_HALVES - 1);

  phase_t            ph_q, ph_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  frame_t            sh_q, sh_d;
  logic              bm_q, bm_d;
  logic [GAP_W-1:0]  gcnt_q, gcnt_d;

  always_comb begin
    ph_d = ph_q; bidx_d = bidx_q; sh_d = sh_q; bm_d = bm_q; gcnt_d = gcnt_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d = PH_CS; sh_d = word; bm_d = byte_mode; bidx_d = '0;
      end
      PH_CS:  if (tick) ph_d = PH_FS;
      PH_FS:  if (tick) ph_d = PH_HI;
      PH_HI:  if (tick) ph_d = PH_LO;
      PH_LO:  if (tick) begin
        sh_d   = sh_q << 1;
        bidx_d = bidx_q + IDX_W'(1);
        if (bidx_q == LAST_IDX) ph_d = PH_TAIL;
        else if (bm_q && bidx_q == BYTE_IDX) begin
          ph_d = PH_GAP; gcnt_d = '0;
        end else ph_d = PH_HI;
      end
      PH_GAP: if (tick) begin
        if (gcnt_q == GAP_END) ph_d = PH_HI;
        else                   gcnt_d = gcnt_q + GAP_W'(1);
      end
      PH_TAIL: if (tick) ph_d = PH_REL;
      PH_REL:  if (tick) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; bidx_q <= '0; sh_q <= '0; bm_q <= 1'b0; gcnt_q <= '0;
    end else begin
      ph_q <= ph_d; bidx_q <= bidx_d; sh_q <= sh_d; bm_q <= bm_d; gcnt_q <= gcnt_d;
    end
  end

  assign run  = (ph_q != PH_IDLE);
  assign done = (ph_q == PH_REL) && tick;
  assign cs_n = (ph_q == PH_IDLE) || (ph_q == PH_REL);
  assign fs   = (ph_q == PH_IDLE) || (ph_q == PH_CS) || (ph_q == PH_REL);
  assign sclk = (ph_q == PH_HI) || (ph_q == PH_TAIL);
  assign dout = sh_q[FRAME_W-1];

  // Observation counters for the protocol checks below
  localparam int LEN_W = HALF_W + 2;
  localparam int FC_W  = $clog2(FRAME_W + 1);
  logic [LEN_W-1:0] hi_len_q, lo_len_q;
  logic [FC_W-1:0]  fcnt_q;
  logic             sclk_d_q;
  logic [LEN_W-1:0] lim_x;
  assign lim_x = {2'b00, lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q <= '0; lo_len_q <= '0; fcnt_q <= '0; sclk_d_q <= 1'b0;
    end else begin
      sclk_d_q <= sclk;
      hi_len_q <= !sclk ? '0 : (&hi_len_q ? hi_len_q : hi_len_q + LEN_W'(1));
      lo_len_q <=  sclk ? '0 : (&lo_len_q ? lo_len_q : lo_len_q + LEN_W'(1));
      fcnt_q   <= cs_n ? '0 : fcnt_q + FC_W'(sclk_d_q & ~sclk);
    end
  end

  p_fs_within_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |-> !cs_n);
  p_fs_before_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (!fs && !cs_n));
  p_din_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(dout));
  p_sixteen_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fcnt_q == FC_W'(FRAME_W)));
  p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_len_q >= lim_x));
  p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_len_q >= lim_x));
  p_tail_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) && $rose(fs)));
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dfs_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              cfg_byte_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_value_only,
  input  logic [1:0]        cmd_sel,
  input  logic              cmd_fast,
  input  logic              cmd_pdown,
  input  logic [1:0]        cmd_ref,
  input  logic [11:0]       cmd_payload,
  output logic              busy,
  output logic              ser_cs_n,
  output logic              ser_fs,
  output logic              ser_sclk,
  output logic              ser_dout
);
  seq_t             seq_q, seq_d;
  frame_t           w1_q, w1_d, w2_q, w2_d;
  logic             two_q, two_d;
  logic             mvld_q, mvld_d, mfast_q, mfast_d;
  logic [REF_W-1:0] mref_q, mref_d;

  frame_t           b_first, b_second;
  logic             b_two, b_upd, b_fast;
  logic [REF_W-1:0] b_ref;

  logic              eng_start, eng_run, eng_done, tick;
  logic [HALF_W-1:0] lim;
  frame_t            eng_word;
  logic              accept;

  dfs_word_build u_build (
    .value_only (cmd_value_only), .sel (cmd_sel), .fast (cmd_fast),
    .pdown (cmd_pdown), .ref_code (cmd_ref), .payload (cmd_payload),
    .mem_vld (mvld_q), .mem_fast (mfast_q), .mem_ref (mref_q),
    .first (b_first), .second (b_second), .two (b_two), .upd (b_upd),
    .new_fast (b_fast), .new_ref (b_ref)
  );

  dfs_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk (clk), .rst_n (rst_n), .run (eng_run), .half_len (cfg_half),
    .lim (lim), .tick (tick)
  );

  dfs_frame_engine #(.HALF_W(HALF_W)) u_engine (
    .clk (clk), .rst_n (rst_n), .start (eng_start), .word (eng_word),
    .byte_mode (cfg_byte_mode), .tick (tick), .lim (lim),
    .run (eng_run), .done (eng_done), .cs_n (ser_cs_n), .fs (ser_fs),
    .sclk (ser_sclk), .dout (ser_dout)
  );

  assign cmd_ready = (seq_q == SQ_IDLE);
  assign busy      = (seq_q != SQ_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign eng_start = (seq_q == SQ_LOAD1) || (seq_q == SQ_LOAD2);
  assign eng_word  = (seq_q == SQ_LOAD2) ? w2_q : w1_q;

  always_comb begin
    seq_d = seq_q; w1_d = w1_q; w2_d = w2_q; two_d = two_q;
    mvld_d = mvld_q; mfast_d = mfast_q; mref_d = mref_q;
    case (seq_q)
      SQ_IDLE: if (accept) begin
        seq_d = SQ_LOAD1; w1_d = b_first; w2_d = b_second; two_d = b_two;
        if (b_upd) begin
          mvld_d = 1'b1; mfast_d = b_fast; mref_d = b_ref;
        end
      end
      SQ_LOAD1: seq_d = SQ_WAIT1;
      SQ_WAIT1: if (eng_done) seq_d = two_q ? SQ_LOAD2 : SQ_IDLE;
      SQ_LOAD2: seq_d = SQ_WAIT2;
      SQ_WAIT2: if (eng_done) seq_d = SQ_IDLE;
      default:  seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE; w1_q <= '0; w2_q <= '0; two_q <= 1'b0;
      mvld_q <= 1'b0; mfast_q <= 1'b0; mref_q <= '0;
    end else begin
      seq_q <= seq_d; w1_q <= w1_d; w2_q <= w2_d; two_q <= two_d;
      mvld_q <= mvld_d; mfast_q <= mfast_d; mref_q <= mref_d;
    end
  end

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_cs_n);
endmodule

// File: tb/tb_dac_frame_seq.sv
`timescale 1ns/1ps
module tb_dac_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_half;
  logic        cfg_byte_mode;
  logic        cmd_valid, cmd_ready, cmd_value_only, cmd_fast, cmd_pdown;
  logic [1:0]  cmd_sel, cmd_ref;
  logic [11:0] cmd_payload;
  logic        busy, ser_cs_n, ser_fs, ser_sclk, ser_dout;

  always #2 clk = ~clk;

  dac_frame_seq dut (
    .clk (clk), .rst_n (rst_n), .cfg_half (cfg_half), .cfg_byte_mode (cfg_byte_mode),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_value_only (cmd_value_only),
    .cmd_sel (cmd_sel), .cmd_fast (cmd_fast), .cmd_pdown (cmd_pdown), .cmd_ref (cmd_ref),
    .cmd_payload (cmd_payload), .busy (busy), .ser_cs_n (ser_cs_n), .ser_fs (ser_fs),
    .ser_sclk (ser_sclk), .ser_dout (ser_dout)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] q_word[$];
  bit          q_bm[$];
  string       q_tag[$];

  bit         m_vld = 0, m_fast = 0;
  logic [1:0] m_ref = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [15:0] w, string tag);
    q_word.push_back(w); q_bm.push_back(cfg_byte_mode); q_tag.push_back(tag);
  endtask

  task automatic send(bit vo, logic [1:0] sel, bit fast, bit pd, logic [1:0] rf,
                      logic [11:0] pl, string tag);
    if (!vo) begin
      push({sel[1], fast, pd, sel[0], pl}, tag);
      if (sel == 2'b11) begin m_vld = 1; m_fast = fast; m_ref = pl[1:0]; end
    end else begin
      if (!(m_vld && m_fast == fast && m_ref == rf)) begin
        push({1'b1, fast, 1'b0, 1'b1, 10'b0, rf}, "R7");
        m_vld = 1; m_fast = fast; m_ref = rf;
      end
      push({1'b0, fast, 2'b00, pl}, tag);
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_value_only = vo; cmd_sel = sel; cmd_fast = fast; cmd_pdown = pd;
    cmd_ref = rf; cmd_payload = pl; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: rebuilds frames from the serial lines and compares to the queue
  logic p_cs = 1, p_fs = 1, p_sk = 0, p_do = 0;
  int   run_len = 0, nf = 0, lim_now, bad_len, exp_len;
  logic [15:0] got;
  bit   in_frm = 0, tim_ok, r1_ok, r2_ok, cur_bm, busy_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      lim_now = (cfg_half == 0) ? 1 : int'(cfg_half);
      if (!ser_cs_n && !busy) busy_bad = 1;
      if (ser_cs_n && !p_cs) begin
        if (in_frm) begin
          if (q_word.size() == 0) chk(0, "R7", "unexpected frame", got, 0);
          else begin
            logic [15:0] ew; bit ebm; string et;
            ew = q_word.pop_front(); ebm = q_bm.pop_front(); et = q_tag.pop_front();
            chk(got == ew, et, "frame word", got, ew);
            chk(nf == 16 && r2_ok, "R2", "falling edge count", nf, 16);
            chk(tim_ok, ebm ? "R9" : "R3", "phase length", bad_len, exp_len);
            chk(r1_ok, "R1", "frame opening order", 0, 1);
            chk(run_len == lim_now && p_sk && !ser_sclk && ser_fs, "R4",
                "closing high phase", run_len, lim_now);
          end
        end
        in_frm = 0;
      end else if (!ser_cs_n && p_cs) begin
        in_frm = 1; got = 0; nf = 0; tim_ok = 1; r2_ok = 1;
        r1_ok = ser_fs && !ser_sclk;
        cur_bm = (q_bm.size() != 0) ? q_bm[0] : 1'b0;
      end else if (in_frm) begin
        if (!ser_fs && p_fs && run_len != lim_now) r1_ok = 0;
        if (ser_fs && !p_fs) r1_ok = 0;
        if (ser_sclk && p_sk && ser_dout != p_do) r2_ok = 0;
        if (ser_sclk && !p_sk) begin
          if (nf == 0) begin
            if (run_len != lim_now || ser_fs) r1_ok = 0;
          end else begin
            int el;
            el = (cur_bm && nf == 8) ? 3 * lim_now : lim_now;
            if (run_len != el) begin tim_ok = 0; bad_len = run_len; exp_len = el; end
          end
        end
        if (!ser_sclk && p_sk) begin
          got = {got[14:0], ser_dout}; nf++;
          if (run_len != lim_now) begin tim_ok = 0; bad_len = run_len; exp_len = lim_now; end
        end
      end
      if (ser_cs_n != p_cs || ser_fs != p_fs || ser_sclk != p_sk) run_len = 1;
      else run_len++;
      p_cs = ser_cs_n; p_fs = ser_fs; p_sk = ser_sclk; p_do = ser_dout;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_half = 8'd1; cfg_byte_mode = 0; cmd_valid = 0; cmd_value_only = 0;
    cmd_sel = 0; cmd_fast = 0; cmd_pdown = 0; cmd_ref = 0; cmd_payload = 0;
    repeat (4) @(negedge clk);
    chk(ser_cs_n && ser_fs && !ser_sclk, "R11", "lines in reset",
        {ser_cs_n, ser_fs, ser_sclk}, 3'b110);
    chk(!busy && cmd_ready, "R11", "handshake in reset", {busy, cmd_ready}, 2'b01);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ser_cs_n && ser_fs && !ser_sclk && !busy, "R11", "lines after reset",
        {ser_cs_n, ser_fs, ser_sclk, busy}, 4'b1100);

    // Full DAC write, fast
    send(0, 2'b00, 1, 0, 2'b00, 12'hABC, "R5"); wait_idle();
    // Control write: fast, internal 2.048 V code -> 0xD002
    send(0, 2'b11, 1, 0, 2'b00, 12'h002, "R8"); wait_idle();
    // Value request matching stored setting -> data frame only
    send(1, 2'b00, 1, 0, 2'b10, 12'h123, "R6"); wait_idle();
    // Mismatch: control frame then data frame
    send(1, 2'b00, 0, 0, 2'b01, 12'hFFF, "R7"); wait_idle();
    send(1, 2'b00, 0, 0, 2'b01, 12'h000, "R8"); wait_idle();
    // Reserved select passes through, slower clock
    @(negedge clk); cfg_half = 8'd2;
    send(0, 2'b01, 0, 0, 2'b00, 12'h0F0, "R5"); wait_idle();
    // Byte mode, half = 3, power-down bit set
    @(negedge clk); cfg_half = 8'd3; cfg_byte_mode = 1;
    send(0, 2'b00, 0, 1, 2'b00, 12'h5A5, "R9"); wait_idle();
    // Byte mode, half = 0 treated as 1, control inserted
    @(negedge clk); cfg_half = 8'd0;
    send(1, 2'b00, 1, 0, 2'b11, 12'h7E1, "R9"); wait_idle();

    // Back-pressure: a second command held while busy must not be taken
    @(negedge clk); cfg_half = 8'd2; cfg_byte_mode = 0;
    send(1, 2'b00, 1, 0, 2'b11, 12'h456, "R6");
    begin
      bit rdy_seen = 0, busy_lost = 0;
      cmd_valid = 1; cmd_value_only = 0; cmd_sel = 2'b00; cmd_payload = 12'h999;
      for (int i = 0; i < 12; i++) begin
        if (cmd_ready) rdy_seen = 1;
        if (!busy) busy_lost = 1;
        @(negedge clk);
      end
      cmd_valid = 0;
      chk(!rdy_seen && !busy_lost, "R10", "ready while busy", rdy_seen, 0);
    end
    wait_idle();

    // Reset clears the remembered setting: same request now needs control again
    rst_n = 0; m_vld = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    send(1, 2'b00, 1, 0, 2'b11, 12'h321, "R8"); wait_idle();

    chk(q_word.size() == 0, "R10", "frames outstanding", q_word.size(), 0);
    chk(!busy_bad, "R10", "busy low while CS low", busy_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule